// File: doc/BRIEF.md
# Three-Wire Serial Register Port

This block is the slave end of a serial control port with three wires: an active-low select, a control clock driven by the host, and one shared data line that carries bits in both directions. The host frames each instruction by pulling the select low. It then clocks in two bytes and raises the select again. The first byte names one of sixteen 8-bit registers and says whether the access is a read or a write. On a write, the second byte replaces the register contents. On a read, the port drives the register contents back over the same data line during the second byte.

All three serial pins are sampled with the chip's system clock through synchronizers, and the block finds the control clock edges from those samples. The register file, the write and read strobes and the register outputs therefore all sit in the system clock domain. Whole-chip logic can use the register outputs directly. It can also use the read strobe to clear status bits when they are read. The data line is modelled as an output value plus an output enable, and the pad cell is not part of this block.

Top module: `ser_regport`

## Requirements
- R1: After reset every register reads 0, no strobe is raised and the data output enable `sdio_oe` is low.
- R2: While `csn_i` is high, activity on `sclk_i` and `sdio_i` changes no register, raises no strobe and leaves `sdio_oe` low.
- R3: Data bits are taken on rising edges of `sclk_i`, most significant bit first. In the first byte, bits [7:4] are the register address, bit [3] selects a read (1) or a write (0), and bits [2:0] have no effect.
- R4: A write frame with exactly 16 rising control clock edges stores the second byte into the addressed register after `csn_i` rises. It also pulses `wr_stb` for one cycle, with `wr_addr` and `wr_data` naming the address and the byte.
- R5: A frame with any other number of rising edges, fewer or more, writes nothing and raises neither strobe.
- R6: In a read frame, the second byte on `sdio_o` is the addressed register's contents, most significant bit first. Each bit changes after a falling edge of `sclk_i`, so the host finds it valid at the following rising edge. `sdio_oe` is high from the end of the first byte until the frame ends.
- R7: `sdio_oe` drops as soon as `csn_i` goes high, without waiting for a system clock edge.
- R8: A read frame with exactly 16 rising edges pulses `rd_stb` for one cycle, with `rd_addr` naming the address. Data bits seen during the second byte of a read never change any register.
- R9: `wr_stb` and `rd_stb` are never high together, and each lasts a single cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| sclk_i | input | 1 | Serial control clock from the host |
| csn_i | input | 1 | Active-low frame select |
| sdio_i | input | 1 | Data line as seen at the pad |
| sdio_o | output | 1 | Read data to drive onto the data line |
| sdio_oe | output | 1 | Output enable for the data line pad |
| regs_o | output | 128 | All registers, register n at bits [8n+7:8n] |
| wr_stb | output | 1 | One-cycle pulse when a write is committed |
| wr_addr | output | 4 | Address of the committed write |
| wr_data | output | 8 | Data of the committed write |
| rd_stb | output | 1 | One-cycle pulse when a read frame completes |
| rd_addr | output | 4 | Address of the completed read |

## Verification
The bench writes and then reads back every address, with each address getting its own data pattern and different values in the ignored header bits. This catches a swapped address field, a wrong read/write bit position, or a read-back that is shifted by one bit, because any of these would return another register's byte or a rotated value. Frames of 15 and 17 edges are sent against registers with known contents. A design that counted loosely would corrupt those registers or raise a strobe. The bench also toggles the clock and data lines while the port is deselected, and sends read frames whose second-byte input is not all zeros. Both would show up as a modified register if the port listened when it should not. Finally, `sdio_oe` is sampled just before and just after the select rises. This exposes an enable that lingers for the synchronizer latency.

// File: rtl/ser_regport_pkg.sv
package ser_regport_pkg;
  localparam int unsigned ADDR_W_DEF = 4;
  localparam int unsigned DATA_W_DEF = 8;
  localparam int unsigned SYNC_DEF   = 2;

  // Width of a counter that holds 0..2*data_w+1 (saturating edge count).
  function automatic int unsigned edge_cnt_w(input int unsigned data_w);
    return $clog2(2 * data_w + 2);
  endfunction
endpackage

// File: rtl/ser_regport_sync.sv
module ser_regport_sync #(
  parameter int unsigned STAGES = 2,
  parameter logic        RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o,
  output logic q_dly_o
);
  logic [STAGES:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= {(STAGES+1){RST_VAL}};
    end else begin
      chain_q <= {chain_q[STAGES-1:0], d_i};
    end
  end

  assign q_o     = chain_q[STAGES-1];
  assign q_dly_o = chain_q[STAGES];
endmodule

// File: rtl/ser_regport_frame.sv
module ser_regport_frame
  import ser_regport_pkg::*;
#(
  parameter int unsigned ADDR_W = ADDR_W_DEF,
  parameter int unsigned DATA_W = DATA_W_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk_s,
  input  logic              sclk_d,
  input  logic              csn_s,
  input  logic              csn_d,
  input  logic              sdi_s,
  input  logic [DATA_W-1:0] rd_word,
  output logic [ADDR_W-1:0] hdr_addr,
  output logic              rd_act,
  output logic              sdo,
  output logic              wr_stb,
  output logic              rd_stb,
  output logic [DATA_W-1:0] dat_word
);
  localparam int unsigned CNT_W  = edge_cnt_w(DATA_W);
  localparam int unsigned RW_POS = DATA_W - 1 - ADDR_W;
  localparam logic [CNT_W-1:0] C_HDR  = CNT_W'(DATA_W);
  localparam logic [CNT_W-1:0] C_FULL = CNT_W'(2 * DATA_W);
  localparam logic [CNT_W-1:0] C_MAX  = CNT_W'(2 * DATA_W + 1);

  logic [CNT_W-1:0]  cnt_q, cnt_n;
  logic [DATA_W-1:0] hdr_q, hdr_n;
  logic [DATA_W-1:0] dat_q, dat_n;
  logic [DATA_W-1:0] out_q, out_n;
  logic              rd_q, rd_n;
  logic              sdo_q, sdo_n;
  logic              wstb_n, rstb_n;
  logic              wstb_q, rstb_q;

  logic sel_start, sel_end, sck_rise, sck_fall;

  assign sel_start = ~csn_s &  csn_d;
  assign sel_end   =  csn_s & ~csn_d;
  assign sck_rise  = ~csn_s &  sclk_s & ~sclk_d;
  assign sck_fall  = ~csn_s & ~sclk_s &  sclk_d;

  always_comb begin
    cnt_n  = cnt_q;
    hdr_n  = hdr_q;
    dat_n  = dat_q;
    out_n  = out_q;
    rd_n   = rd_q;
    sdo_n  = sdo_q;
    wstb_n = 1'b0;
    rstb_n = 1'b0;
    if (sel_start) begin
      cnt_n = '0;
      rd_n  = 1'b0;
    end else if (sel_end) begin
      wstb_n = (cnt_q == C_FULL) & ~rd_q;
      rstb_n = (cnt_q == C_FULL) &  rd_q;
      rd_n   = 1'b0;
    end else if (sck_rise) begin
      if (cnt_q != C_MAX) cnt_n = cnt_q + 1'b1;
      if (cnt_q < C_HDR) begin
        hdr_n = {hdr_q[DATA_W-2:0], sdi_s};
        if (cnt_q == C_HDR - 1'b1) rd_n = hdr_n[RW_POS];
      end else if ((cnt_q < C_FULL) && !rd_q) begin
        dat_n = {dat_q[DATA_W-2:0], sdi_s};
      end
    end else if (sck_fall && rd_q && (cnt_q >= C_HDR) && (cnt_q < C_FULL)) begin
      if (cnt_q == C_HDR) begin
        sdo_n = rd_word[DATA_W-1];
        out_n = {rd_word[DATA_W-2:0], 1'b0};
      end else begin
        sdo_n = out_q[DATA_W-1];
        out_n = {out_q[DATA_W-2:0], 1'b0};
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      hdr_q  <= '0;
      dat_q  <= '0;
      out_q  <= '0;
      rd_q   <= 1'b0;
      sdo_q  <= 1'b0;
      wstb_q <= 1'b0;
      rstb_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_n;
      hdr_q  <= hdr_n;
      dat_q  <= dat_n;
      out_q  <= out_n;
      rd_q   <= rd_n;
      sdo_q  <= sdo_n;
      wstb_q <= wstb_n;
      rstb_q <= rstb_n;
    end
  end

  assign hdr_addr = hdr_q[DATA_W-1 -: ADDR_W];
  assign rd_act   = rd_q;
  assign sdo      = sdo_q;
  assign wr_stb   = wstb_q;
  assign rd_stb   = rstb_q;
  assign dat_word = dat_q;
endmodule

// File: rtl/ser_regport_regfile.sv
module ser_regport_regfile
  import ser_regport_pkg::*;
#(
  parameter int unsigned ADDR_W = ADDR_W_DEF,
  parameter int unsigned DATA_W = DATA_W_DEF
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           wr_en,
  input  logic [ADDR_W-1:0]              wr_addr,
  input  logic [DATA_W-1:0]              wr_data,
  input  logic [ADDR_W-1:0]              rd_addr,
  output logic [DATA_W-1:0]              rd_data,
  output logic [(1<<ADDR_W)*DATA_W-1:0]  regs_flat
);
  localparam int unsigned NREG = 1 << ADDR_W;

  logic [DATA_W-1:0] mem_q [NREG];

  for (genvar gi = 0; gi < NREG; gi++) begin : g_reg
    logic sel;
    assign sel = wr_en && (wr_addr == ADDR_W'(gi));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        mem_q[gi] <= '0;
      end else if (sel) begin
        mem_q[gi] <= wr_data;
      end
    end
    assign regs_flat[gi*DATA_W +: DATA_W] = mem_q[gi];
  end

  assign rd_data = mem_q[rd_addr];
endmodule

// File: rtl/ser_regport.sv
module ser_regport
  import ser_regport_pkg::*;
#(
  parameter int unsigned ADDR_W      = ADDR_W_DEF,
  parameter int unsigned DATA_W      = DATA_W_DEF,
  parameter int unsigned SYNC_STAGES = SYNC_DEF
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          sclk_i,
  input  logic                          csn_i,
  input  logic                          sdio_i,
  output logic                          sdio_o,
  output logic                          sdio_oe,
  output logic [(1<<ADDR_W)*DATA_W-1:0] regs_o,
  output logic                          wr_stb,
  output logic [ADDR_W-1:0]             wr_addr,
  output logic [DATA_W-1:0]             wr_data,
  output logic                          rd_stb,
  output logic [ADDR_W-1:0]             rd_addr
);
  logic [1:0] rst_sync_q;
  logic       rst_i_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_i_n = rst_sync_q[1];

  logic sclk_s, sclk_d, csn_s, csn_d, sdi_s, sdi_d;

  ser_regport_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_sclk (
    .clk(clk), .rst_n(rst_i_n), .d_i(sclk_i), .q_o(sclk_s), .q_dly_o(sclk_d));
  ser_regport_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_csn (
    .clk(clk), .rst_n(rst_i_n), .d_i(csn_i), .q_o(csn_s), .q_dly_o(csn_d));
  ser_regport_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_sdi (
    .clk(clk), .rst_n(rst_i_n), .d_i(sdio_i), .q_o(sdi_s), .q_dly_o(sdi_d));

  logic [ADDR_W-1:0] hdr_addr;
  logic [DATA_W-1:0] rd_word, dat_word;
  logic              rd_act, sdo, wstb, rstb;
  logic              unused_sdi_d;
  assign unused_sdi_d = sdi_d;

  ser_regport_frame #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_frame (
    .clk(clk), .rst_n(rst_i_n),
    .sclk_s(sclk_s), .sclk_d(sclk_d), .csn_s(csn_s), .csn_d(csn_d), .sdi_s(sdi_s),
    .rd_word(rd_word), .hdr_addr(hdr_addr), .rd_act(rd_act), .sdo(sdo),
    .wr_stb(wstb), .rd_stb(rstb), .dat_word(dat_word));

  ser_regport_regfile #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_i_n),
    .wr_en(wstb), .wr_addr(hdr_addr), .wr_data(dat_word),
    .rd_addr(hdr_addr), .rd_data(rd_word), .regs_flat(regs_o));

  // Enable is gated by the raw select so it releases without sync latency.
  assign sdio_oe = rd_act & ~csn_i;
  assign sdio_o  = sdo;
  assign wr_stb  = wstb;
  assign wr_addr = hdr_addr;
  assign wr_data = dat_word;
  assign rd_stb  = rstb;
  assign rd_addr = hdr_addr;
endmodule

// File: rtl/ser_regport_chk.sv
module ser_regport_chk #(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned DATA_W = 8
) (
  input logic                          clk,
  input logic                          rst_n,
  input logic                          csn_i,
  input logic                          sdio_oe,
  input logic [(1<<ADDR_W)*DATA_W-1:0] regs_o,
  input logic                          wr_stb,
  input logic [ADDR_W-1:0]             wr_addr,
  input logic [DATA_W-1:0]             wr_data,
  input logic                          rd_stb
);
  AST_OE_DESELECT: assert property (@(posedge clk) disable iff (!rst_n)
    csn_i |-> !sdio_oe); // R2

  AST_WR_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |=> regs_o[$past(wr_addr)*DATA_W +: DATA_W] == $past(wr_data)); // R4

  AST_REGS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_stb |=> $stable(regs_o)); // R8

  AST_STB_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_stb && rd_stb)); // R9

  AST_WR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb |=> !wr_stb); // R9

  AST_RD_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stb |=> !rd_stb); // R9
endmodule

bind ser_regport ser_regport_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .csn_i(csn_i), .sdio_oe(sdio_oe), .regs_o(regs_o),
  .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data), .rd_stb(rd_stb));

// File: tb/ser_regport_tb.sv
module ser_regport_tb;
  localparam int HALF = 6;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         sclk_i = 1'b0;
  logic         csn_i = 1'b1;
  logic         sdio_i = 1'b0;
  logic         sdio_o, sdio_oe;
  logic [127:0] regs_o;
  logic         wr_stb, rd_stb;
  logic [3:0]   wr_addr, rd_addr;
  logic [7:0]   wr_data;

  ser_regport u_dut (
    .clk(clk), .rst_n(rst_n), .sclk_i(sclk_i), .csn_i(csn_i), .sdio_i(sdio_i),
    .sdio_o(sdio_o), .sdio_oe(sdio_oe), .regs_o(regs_o),
    .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_stb(rd_stb), .rd_addr(rd_addr));

  always #10 clk = ~clk;

  int total = 0, bad = 0;
  int wr_cnt = 0, rd_cnt = 0;
  logic [3:0] last_wa, last_ra;
  logic [7:0] last_wd;
  logic [7:0] model [16];
  bit done = 0;

  always @(negedge clk) begin
    if (rst_n && wr_stb) begin wr_cnt++; last_wa = wr_addr; last_wd = wr_data; end
    if (rst_n && rd_stb) begin rd_cnt++; last_ra = rd_addr; end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  function automatic logic [7:0] pat(input int a, input int pass);
    return 8'((a * 37 + 11 + pass * 90) ^ (a << 4));
  endfunction

  task automatic regs_match(input string tag);
    for (int a = 0; a < 16; a++)
      chk(regs_o[a*8 +: 8] == model[a], tag, regs_o[a*8 +: 8], model[a]);
  endtask

  // Sends nbits bits from the top of bits; captures read data and oe state.
  task automatic frame(input int nbits, input logic [23:0] bits,
                       output logic [7:0] rx, output bit oe_seen, output bit oe_end);
    rx = '0; oe_seen = 1;
    @(negedge clk); csn_i = 1'b0;
    repeat (HALF) @(negedge clk);
    for (int i = 0; i < nbits; i++) begin
      sdio_i = bits[23 - i];
      repeat (HALF) @(negedge clk);
      if (i >= 8 && i < 16) begin
        rx = {rx[6:0], sdio_o};
        oe_seen = oe_seen & sdio_oe;
      end
      sclk_i = 1'b1;
      repeat (HALF) @(negedge clk);
      sclk_i = 1'b0;
    end
    repeat (HALF) @(negedge clk);
    oe_end = sdio_oe;
    csn_i = 1'b1;
    #1;
    oe_end = oe_end & ~sdio_oe;
    repeat (10) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=hung expected=done");
    finish_run();
  end

  initial begin
    logic [7:0] rx;
    bit oe_s, oe_e;
    int w0, r0;
    for (int a = 0; a < 16; a++) model[a] = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);

    // R1 reset state
    regs_match("R1 reset regs");
    chk(sdio_oe == 0, "R1 oe", sdio_oe, 0);
    chk(wr_cnt == 0 && rd_cnt == 0, "R1 strobes", wr_cnt + rd_cnt, 0);

    // R3 R4 write every address, header don't-care bits vary
    for (int a = 0; a < 16; a++) begin
      w0 = wr_cnt;
      frame(16, {4'(a), 1'b0, 3'(a ^ 5), pat(a, 0), 8'h00}, rx, oe_s, oe_e);
      model[a] = pat(a, 0);
      chk(wr_cnt == w0 + 1, "R4 wr_stb count", wr_cnt - w0, 1);
      chk(last_wa == 4'(a) && last_wd == pat(a, 0), "R4 wr addr/data",
          {last_wa, last_wd}, {4'(a), pat(a, 0)});
      chk(sdio_oe == 0, "R3 oe low on write", sdio_oe, 0);
    end
    regs_match("R4 regs after writes");

    // R6 R7 R8 read every address; second-byte input is nonzero and ignored
    for (int a = 15; a >= 0; a--) begin
      r0 = rd_cnt;
      frame(16, {4'(a), 1'b1, 3'(~a), 8'hA5, 8'h00}, rx, oe_s, oe_e);
      chk(rx == model[a], "R6 read data", rx, model[a]);
      chk(oe_s, "R6 oe during data", oe_s, 1);
      chk(oe_e, "R7 oe released at select rise", oe_e, 1);
      chk(rd_cnt == r0 + 1 && last_ra == 4'(a), "R8 rd_stb addr", last_ra, a);
    end
    regs_match("R8 regs unchanged by reads");

    // R5 short and long write frames discarded
    w0 = wr_cnt; r0 = rd_cnt;
    frame(15, {4'd3, 1'b0, 3'd0, 8'hFF, 8'h00}, rx, oe_s, oe_e);
    frame(17, {4'd7, 1'b0, 3'd0, 8'h00, 8'hFF}, rx, oe_s, oe_e);
    frame(8, {4'd9, 1'b0, 3'd0, 16'h0000}, rx, oe_s, oe_e);
    frame(15, {4'd2, 1'b1, 3'd0, 16'h0000}, rx, oe_s, oe_e);
    frame(20, {4'd2, 1'b1, 3'd0, 16'hFFFF}, rx, oe_s, oe_e);
    chk(wr_cnt == w0, "R5 no wr_stb", wr_cnt - w0, 0);
    chk(rd_cnt == r0, "R5 no rd_stb", rd_cnt - r0, 0);
    regs_match("R5 regs unchanged");

    // R2 activity while deselected
    w0 = wr_cnt; r0 = rd_cnt;
    for (int i = 0; i < 24; i++) begin
      sdio_i = i[1];
      repeat (HALF) @(negedge clk); sclk_i = 1'b1;
      if (sdio_oe) chk(0, "R2 oe while deselected", 1, 0);
      repeat (HALF) @(negedge clk); sclk_i = 1'b0;
    end
    repeat (8) @(negedge clk);
    chk(wr_cnt == w0 && rd_cnt == r0, "R2 no strobe", wr_cnt + rd_cnt - w0 - r0, 0);
    chk(sdio_oe == 0, "R2 oe low", sdio_oe, 0);
    regs_match("R2 regs unchanged");

    // R4 R6 overwrite a few and read back, including all-ones and all-zero bytes
    for (int k = 0; k < 4; k++) begin
      int a;
      logic [7:0] v;
      a = k * 5;
      v = (k == 0) ? 8'hFF : (k == 1) ? 8'h00 : pat(a, 1);
      frame(16, {4'(a), 1'b0, 3'b111, v, 8'h00}, rx, oe_s, oe_e);
      model[a] = v;
      frame(16, {4'(a), 1'b1, 3'b000, 8'h5A, 8'h00}, rx, oe_s, oe_e);
      chk(rx == v, "R6 readback after overwrite", rx, v);
    end
    regs_match("R4 regs after overwrite");

    // R9 strobe pulse width observed at ports
    w0 = 0;
    fork
      frame(16, {4'd1, 1'b0, 3'd0, 8'h3C, 8'h00}, rx, oe_s, oe_e);
      begin
        repeat (16 * 2 * HALF + 4 * HALF) begin
          @(negedge clk);
          if (wr_stb) w0++;
        end
      end
    join
    model[1] = 8'h3C;
    chk(w0 == 1, "R9 wr_stb width", w0, 1);
    regs_match("R9 regs final");

    finish_run();
  end
endmodule